// File: doc/BRIEF.md
# Two-Channel Label Entry Controller

This block takes keystrokes from a matrix keypad and writes them as short text labels into one of two ten-position character buffers, called upper and lower. The keypad presents one line per row and one line per column, one of each active for a key. The block turns each line group into a 4-bit code and stores the row code and the column code as separate fields. Two buttons pick the buffer that receives writes. The write address is shared by both buffers. It steps forward once per accepted key and stops at the tenth position, where later keys overwrite the last character.

An erase button clears the selected buffer. The erase runs in step with an external time-slot pulse. Each slot pulse in the sweep writes the all-zero blank code at the current address and moves the address on, wrapping after the last position. When the sweep has counted its slot pulses, a one-cycle reset phase returns the address to zero and clears the full flag. A small combinational read port lets the display side, or a test, fetch any stored character.

Top module: `label_entry_ctrl`

## Requirements
- R1: `sel_upper_btn` selects the upper buffer and `sel_lower_btn` selects the lower one. Pressing both at once keeps the current choice, and reset chooses upper. Only the enable of the selected buffer (`we_upper` or `we_lower`) ever pulses. The two buffers share one write address, and changing buffers leaves that address where it is.
- R2: Each buffer has exactly ten positions, at addresses 0 to 9. `wr_addr` never leaves that range, and a read at address 10 or above returns zero.
- R3: An accepted key makes a single one-cycle write at the current `wr_addr`. The address then goes up by one.
- R4: A key written at address 9 sets `buf_full`. After that the address stays at 9, so each new key replaces the character at address 9.
- R5: Row line i is stored as row code i. Column line i is stored as column code i+1, so a key never stores a zero column code. When several lines of a group are active, the lowest-numbered line is used.
- R6: Only column activity detects a key. Row lines alone cause no write.
- R7: The combined column activity has to stay at a new level for `DEB_CYCLES` consecutive cycles after a two-flop synchronizer before it counts. One held press gives exactly one write. Glitches shorter than that give none.
- R8: A rising edge on `erase_btn` starts a sweep of `ERASE_SLOTS` slot pulses, where `ERASE_SLOTS` must be at least 10. Each pulse writes row 0 and column 0 at the current address and then advances it, wrapping from 9 to 0. `erase_busy` is high for the whole sweep, and keys are ignored during it.
- R9: After the sweep, a one-cycle reset phase sets `wr_addr` to 0 and clears `buf_full`, and then `erase_busy` falls.
- R10: An erase clears only the buffer selected when it runs. The other buffer keeps its contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_upper_btn | input | 1 | Select upper buffer |
| sel_lower_btn | input | 1 | Select lower buffer |
| key_row | input | KEY_ROWS | Keypad row lines, active high |
| key_col | input | KEY_COLS | Keypad column lines, active high |
| erase_btn | input | 1 | Erase request, acts on its rising edge |
| slot_tick | input | 1 | One-cycle time-slot pulse |
| rd_lower | input | 1 | Read port buffer choice (1 = lower) |
| rd_addr | input | 4 | Read port address |
| rd_row | output | 4 | Stored row code at the read address |
| rd_col | output | 4 | Stored column code at the read address |
| we_upper | output | 1 | Upper buffer write enable |
| we_lower | output | 1 | Lower buffer write enable |
| wr_addr | output | 4 | Current write address |
| wr_row | output | 4 | Row code being written |
| wr_col | output | 4 | Column code being written |
| lower_active | output | 1 | 1 when the lower buffer is selected |
| buf_full | output | 1 | Address locked at the last position |
| erase_busy | output | 1 | Erase sweep or reset phase in progress |

## Verification
The hardest state to reach is an erase that starts from a locked pointer. That sweep begins at address 9 and has to wrap. During it, a full debounced keystroke arrives that must leave no trace. The stimulus first fills the lower buffer past its tenth key, which overwrites address 9 twice. It then switches to the upper buffer and erases while the address is still at 9. In the middle of the sweep it holds a key long enough to pass the debouncer. The scoreboard expects exactly the twelve blank writes, starting from the wrapped address and with no extra write. Read-back then shows the lower buffer unchanged and the upper one blank.

// File: rtl/label_entry_ctrl.sv
module label_entry_ctrl #(
  parameter int SLOTS       = 10,
  parameter int KEY_ROWS    = 10,
  parameter int KEY_COLS    = 9,
  parameter int DEB_CYCLES  = 16,
  parameter int ERASE_SLOTS = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sel_upper_btn,
  input  logic                sel_lower_btn,
  input  logic [KEY_ROWS-1:0] key_row,
  input  logic [KEY_COLS-1:0] key_col,
  input  logic                erase_btn,
  input  logic                slot_tick,
  input  logic                rd_lower,
  input  logic [3:0]          rd_addr,
  output logic [3:0]          rd_row,
  output logic [3:0]          rd_col,
  output logic                we_upper,
  output logic                we_lower,
  output logic [3:0]          wr_addr,
  output logic [3:0]          wr_row,
  output logic [3:0]          wr_col,
  output logic                lower_active,
  output logic                buf_full,
  output logic                erase_busy
);
  localparam int DW = $clog2(DEB_CYCLES + 1);
  localparam int EW = $clog2(ERASE_SLOTS + 1);
  localparam logic [3:0] LAST = 4'(SLOTS - 1);

  typedef enum logic [1:0] {S_IDLE, S_SWEEP, S_RESET} state_t;
  state_t state;

  logic [1:0]    col_sync;
  logic          deb_lvl;
  logic [DW-1:0] deb_cnt;
  logic          key_hit;
  logic [1:0]    ers_sync;
  logic          ers_prev;
  logic          ers_rise;
  logic          pend;
  logic [3:0]    pend_row, pend_col;
  logic [EW-1:0] slots_left;
  logic [3:0]    ptr;
  logic          full;
  logic          chan_lo;
  logic          key_we, ers_we, any_we;
  logic [3:0]    enc_row, enc_col;

  logic [3:0] mem_row [2][SLOTS];
  logic [3:0] mem_col [2][SLOTS];

  always_comb begin
    enc_row = 4'd0;
    for (int i = KEY_ROWS - 1; i >= 0; i--)
      if (key_row[i]) enc_row = 4'(i);
  end

  always_comb begin
    enc_col = 4'd0;
    for (int i = KEY_COLS - 1; i >= 0; i--)
      if (key_col[i]) enc_col = 4'(i + 1);
  end

  assign key_hit  = col_sync[1] && !deb_lvl && (deb_cnt == DW'(DEB_CYCLES - 1));
  assign ers_rise = ers_sync[1] && !ers_prev;
  assign key_we   = pend && (state == S_IDLE);
  assign ers_we   = (state == S_SWEEP) && slot_tick;
  assign any_we   = key_we || ers_we;

  assign we_upper     = any_we && !chan_lo;
  assign we_lower     = any_we && chan_lo;
  assign wr_addr      = ptr;
  assign wr_row       = ers_we ? 4'd0 : pend_row;
  assign wr_col       = ers_we ? 4'd0 : pend_col;
  assign lower_active = chan_lo;
  assign buf_full     = full;
  assign erase_busy   = (state != S_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      col_sync <= '0;
      deb_lvl  <= 1'b0;
      deb_cnt  <= '0;
      ers_sync <= '0;
      ers_prev <= 1'b0;
      chan_lo  <= 1'b0;
    end else begin
      col_sync <= {col_sync[0], |key_col};
      ers_sync <= {ers_sync[0], erase_btn};
      ers_prev <= ers_sync[1];
      if (sel_upper_btn && !sel_lower_btn) chan_lo <= 1'b0;
      else if (sel_lower_btn && !sel_upper_btn) chan_lo <= 1'b1;
      if (col_sync[1] == deb_lvl) deb_cnt <= '0;
      else if (deb_cnt == DW'(DEB_CYCLES - 1)) begin
        deb_lvl <= col_sync[1];
        deb_cnt <= '0;
      end else deb_cnt <= deb_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      pend       <= 1'b0;
      pend_row   <= '0;
      pend_col   <= '0;
      slots_left <= '0;
      ptr        <= '0;
      full       <= 1'b0;
    end else begin
      pend <= 1'b0;
      if (key_we) begin
        if (ptr == LAST) full <= 1'b1;
        else ptr <= ptr + 1'b1;
      end
      unique case (state)
        S_IDLE: begin
          if (ers_rise) begin
            state      <= S_SWEEP;
            full       <= 1'b0;
            slots_left <= EW'(ERASE_SLOTS);
          end else if (key_hit) begin
            pend     <= 1'b1;
            pend_row <= enc_row;
            pend_col <= enc_col;
          end
        end
        S_SWEEP: begin
          full <= 1'b0;
          if (slot_tick) begin
            ptr        <= (ptr == LAST) ? 4'd0 : ptr + 1'b1;
            slots_left <= slots_left - 1'b1;
            if (slots_left == EW'(1)) state <= S_RESET;
          end
        end
        S_RESET: begin
          ptr   <= '0;
          full  <= 1'b0;
          state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < 2; c++)
        for (int a = 0; a < SLOTS; a++) begin
          mem_row[c][a] <= '0;
          mem_col[c][a] <= '0;
        end
    end else if (any_we) begin
      mem_row[chan_lo][ptr] <= wr_row;
      mem_col[chan_lo][ptr] <= wr_col;
    end
  end

  always_comb begin
    rd_row = '0;
    rd_col = '0;
    if (rd_addr < 4'(SLOTS)) begin
      rd_row = mem_row[rd_lower][rd_addr];
      rd_col = mem_col[rd_lower][rd_addr];
    end
  end
endmodule

// File: rtl/label_entry_chk.sv
module label_entry_chk #(
  parameter int SLOTS = 10
) (
  input logic       clk,
  input logic       rst_n,
  input logic       we_upper,
  input logic       we_lower,
  input logic       lower_active,
  input logic [3:0] wr_addr,
  input logic [3:0] wr_row,
  input logic [3:0] wr_col,
  input logic       buf_full,
  input logic       erase_busy
);
  localparam logic [3:0] LAST = 4'(SLOTS - 1);
  logic we;
  assign we = we_upper || we_lower;

  p_one_enable_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({we_upper, we_lower}));
  p_enable_follows_sel_r1: assert property (@(posedge clk) disable iff (!rst_n)
    we_upper |-> !lower_active);
  p_addr_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_addr <= LAST);
  p_key_advance_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !erase_busy && wr_addr != LAST) |=> wr_addr == $past(wr_addr) + 4'd1);
  p_lock_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !erase_busy && wr_addr == LAST) |=> (wr_addr == LAST && buf_full));
  p_key_col_nonzero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !erase_busy) |-> wr_col != 4'd0);
  p_erase_blank_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (we && erase_busy) |-> (wr_row == 4'd0 && wr_col == 4'd0));
  p_erase_exit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(erase_busy) |-> (wr_addr == 4'd0 && !buf_full));
endmodule

bind label_entry_ctrl label_entry_chk #(.SLOTS(SLOTS)) u_chk (
  .clk(clk), .rst_n(rst_n), .we_upper(we_upper), .we_lower(we_lower),
  .lower_active(lower_active), .wr_addr(wr_addr), .wr_row(wr_row),
  .wr_col(wr_col), .buf_full(buf_full), .erase_busy(erase_busy));

// File: tb/tb_label_entry_ctrl.sv
`timescale 1ns/1ps
module tb_label_entry_ctrl;
  localparam int SLOTS = 10, KR = 10, KC = 9, DEB = 16, ES = 12, TICK = 20;

  logic clk = 0, rst_n = 0;
  logic sel_u = 0, sel_l = 0, ers = 0, tick = 0, rd_lo = 0;
  logic [KR-1:0] krow = '0;
  logic [KC-1:0] kcol = '0;
  logic [3:0] rd_a = '0;
  logic [3:0] rd_row, rd_col, wr_addr, wr_row, wr_col;
  logic we_u, we_l, lo_act, full, busy;

  always #4 clk = ~clk;

  label_entry_ctrl #(.SLOTS(SLOTS), .KEY_ROWS(KR), .KEY_COLS(KC),
                     .DEB_CYCLES(DEB), .ERASE_SLOTS(ES)) dut (
    .clk(clk), .rst_n(rst_n), .sel_upper_btn(sel_u), .sel_lower_btn(sel_l),
    .key_row(krow), .key_col(kcol), .erase_btn(ers), .slot_tick(tick),
    .rd_lower(rd_lo), .rd_addr(rd_a), .rd_row(rd_row), .rd_col(rd_col),
    .we_upper(we_u), .we_lower(we_l), .wr_addr(wr_addr), .wr_row(wr_row),
    .wr_col(wr_col), .lower_active(lo_act), .buf_full(full), .erase_busy(busy));

  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;
  logic [12:0] expq[$];
  int m_ptr = 0; bit m_full = 0; bit m_lo = 0;
  logic [3:0] m_row [2][SLOTS];
  logic [3:0] m_col [2][SLOTS];

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc % TICK == 0) begin #1 tick = 1; end
    else begin #1 tick = 0; end
    if (cyc > 150000 && !done) begin
      fails++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  always @(negedge clk) if (rst_n && (we_u || we_l)) begin
    checks++;
    if (expq.size() == 0) begin
      fails++;
      $display("FAIL R3/R6/R7/R8 unexpected write actual=%0h expected=none",
               {we_l, wr_addr, wr_row, wr_col});
    end else begin
      logic [12:0] e;
      e = expq.pop_front();
      if ({we_l, wr_addr, wr_row, wr_col} !== e) begin
        fails++;
        $display("FAIL R1/R3/R5 write actual=%0h expected=%0h",
                 {we_l, wr_addr, wr_row, wr_col}, e);
      end
    end
  end

  task automatic cyc_wait(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  function automatic logic [3:0] enc_r(logic [KR-1:0] r);
    for (int i = 0; i < KR; i++) if (r[i]) return 4'(i);
    return 4'd0;
  endfunction
  function automatic logic [3:0] enc_c(logic [KC-1:0] c);
    for (int i = 0; i < KC; i++) if (c[i]) return 4'(i + 1);
    return 4'd0;
  endfunction

  task automatic press(logic [KR-1:0] r, logic [KC-1:0] c, bit expect_wr);
    if (expect_wr && c != 0) begin
      expq.push_back({m_lo, 4'(m_ptr), enc_r(r), enc_c(c)});
      m_row[m_lo][m_ptr] = enc_r(r);
      m_col[m_lo][m_ptr] = enc_c(c);
      if (m_ptr == SLOTS - 1) m_full = 1; else m_ptr++;
    end
    @(posedge clk); #1 krow = r; kcol = c;
    cyc_wait(DEB + 10);
    krow = '0; kcol = '0;
    cyc_wait(DEB + 10);
  endtask

  task automatic select(bit lo);
    @(posedge clk); #1 if (lo) sel_l = 1; else sel_u = 1;
    cyc_wait(1); sel_l = 0; sel_u = 0;
    m_lo = lo;
    cyc_wait(1);
  endtask

  task automatic readback(string req);
    for (int c = 0; c < 2; c++)
      for (int a = 0; a < SLOTS; a++) begin
        rd_lo = c[0]; rd_a = 4'(a); #1;
        chk(req, {rd_row, rd_col}, {m_row[c][a], m_col[c][a]});
      end
  endtask

  initial begin
    for (int c = 0; c < 2; c++)
      for (int a = 0; a < SLOTS; a++) begin m_row[c][a] = 0; m_col[c][a] = 0; end
    cyc_wait(5);
    rst_n = 1;
    cyc_wait(2);
    // reset state (R1 R2 R4 R9)
    chk("R2 reset addr", wr_addr, 0);
    chk("R1 reset enables/sel", {we_u, we_l, lo_act}, 0);
    chk("R4 reset full", {full, busy}, 0);

    // R3 R5: upper buffer, distinct keys
    press(10'b0000000001, 9'b000000001, 1);
    press(10'b0000100000, 9'b000010000, 1);
    press(10'b1000000000, 9'b100000000, 1);
    chk("R3 addr after 3 keys", wr_addr, 3);

    // R1: both buttons hold, lower continues shared address
    @(posedge clk); #1 sel_u = 1; sel_l = 1; cyc_wait(1); sel_u = 0; sel_l = 0; cyc_wait(1);
    chk("R1 both buttons hold", lo_act, 0);
    select(1);
    chk("R1 lower selected", lo_act, 1);
    press(10'b0000000100, 9'b000000100, 1);
    press(10'b0001000000, 9'b001000000, 1);

    // R7: bounce shorter than debounce window
    for (int i = 0; i < 6; i++) begin
      @(posedge clk); #1 kcol = 9'b000000010;
      cyc_wait(DEB / 3);
      kcol = '0;
      cyc_wait(DEB / 3);
    end
    cyc_wait(DEB + 4);
    chk("R7 no write on bounce", wr_addr, 5);

    // R6: row only
    press(10'b0000010000, 9'b0, 0);
    chk("R6 row-only ignored", wr_addr, 5);

    // R5: multiple lines, lowest wins
    press(10'b0100001000, 9'b000100100, 1);

    // R4: fill to lock then overwrite
    while (m_ptr < SLOTS - 1 || !m_full)
      press(10'b0000000010, 9'b000001000, 1);
    chk("R4 locked addr", {full, wr_addr}, {1'b1, 4'd9});
    press(10'b0010000000, 9'b010000000, 1);
    press(10'b0000000001, 9'b000000001, 1);
    chk("R4 still locked", {full, wr_addr}, {1'b1, 4'd9});
    readback("R4/R5 readback");
    rd_a = 4'd12; rd_lo = 1; #1;
    chk("R2 out-of-range read", {rd_row, rd_col}, 0);

    // R8 R9 R10: erase upper from locked address
    select(0);
    for (int k = 0; k < ES; k++) begin
      expq.push_back({1'b0, 4'(m_ptr), 8'h00});
      m_row[0][m_ptr] = 0; m_col[0][m_ptr] = 0;
      m_ptr = (m_ptr == SLOTS - 1) ? 0 : m_ptr + 1;
    end
    m_ptr = 0; m_full = 0;
    @(posedge clk); #1 ers = 1; cyc_wait(6); ers = 0;
    chk("R8 busy during sweep", {busy, full}, {1'b1, 1'b0});
    press(10'b0000000001, 9'b000000001, 0);   // R8 ignored during erase
    chk("R8 still busy", busy, 1);
    while (busy) cyc_wait(1);
    chk("R9 addr and full after erase", {full, wr_addr}, 0);
    chk("R8 all sweep writes seen", expq.size(), 0);
    readback("R8/R10 readback");

    press(10'b0000001000, 9'b000000010, 1);
    chk("R9 write restarts at 0", wr_addr, 1);
    cyc_wait(10);
    chk("R3 scoreboard drained", expq.size(), 0);
    done = 1;
    summary();
  end
endmodule